// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node directory for one slice of a distributed shared memory. It keeps one directory entry per line in a synchronous RAM. Each entry holds a coherence state, a small set of sharer pointer slots and an overflow flag. Requests come in as a read or a write from a numbered node for a line index. The controller reads the entry, decides what the request needs, and sends out protocol messages. A downgrade goes to a clean owner, a forward goes to a dirty owner, and invalidates go to recorded holders. Once the protocol step is finished, it grants the line to the requester.

Requests are taken one at a time. The `req_ready` output is high only while the controller is idle. A write that must invalidate other holders waits until every invalidate has been acknowledged. A read of a dirty line waits for the owner's forward reply. When a new sharer arrives and every pointer slot is taken, the entry is marked overflowed and a trap pulse asks software to track the extra node. A later write to that line raises a trap again so that software can invalidate the extra nodes.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low for exactly LINES cycles while every directory entry is cleared to unused. After that, any line reads as unused.
- R2: A read of an unused line gives one grant with `grant_excl`=1 to the requester and sends no message. The requester becomes the clean owner.
- R3: A read of a clean-owned line by another node sends one message of kind 2 (downgrade) to the owner and grants with `grant_excl`=0. Both nodes are then recorded as sharers.
- R4: A read of a dirty-owned line by another node sends one message of kind 3 (forward) to the owner. No grant is given until `fwd_rsp_valid`. If `fwd_rsp_dirty`=1, the line becomes shared by the owner and the requester, and the grant is shared. If `fwd_rsp_dirty`=0, the requester becomes sole clean owner, and the grant is exclusive.
- R5: A write sends one message of kind 1 (invalidate) to each recorded holder other than the writer, one per cycle. No other node receives one.
- R6: A write that sent N invalidates gives no grant, and keeps `req_ready` low, until N pulses of `inv_ack_valid` have arrived.
- R7: A completed write leaves the writer as the sole dirty owner, with all other pointers cleared.
- R8: A line holds up to SLOTS (default 4) distinct sharers. A further distinct reader sets the overflow flag and causes a one-cycle `trap_valid` pulse with `trap_write`=0 and that node and line. The reader is still granted shared.
- R9: A write to an overflowed line causes a trap pulse with `trap_write`=1. The completed write clears the overflow flag.
- R10: A read by a node already recorded for the line is granted at once. It sends no message and leaves the entry unchanged.
- R11: A write to an unused line, or by the line's sole owner, is granted exclusive at once with no invalidate.
- R12: `grant_valid` and `trap_valid` are single-cycle pulses, and each request yields exactly one grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_node | input | NODE_W | Requesting node |
| req_line | input | LINE_W | Line index |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| fwd_rsp_valid | input | 1 | Owner's reply to a forward |
| fwd_rsp_dirty | input | 1 | Owner's reply carried modified data |
| inv_ack_valid | input | 1 | One invalidate acknowledgement |
| msg_valid | output | 1 | Protocol message out |
| msg_kind | output | 2 | 1 invalidate, 2 downgrade, 3 forward |
| msg_node | output | NODE_W | Message destination |
| msg_line | output | LINE_W | Message line |
| grant_valid | output | 1 | Grant to requester |
| grant_excl | output | 1 | 1 exclusive, 0 shared |
| grant_node | output | NODE_W | Granted node |
| grant_line | output | LINE_W | Granted line |
| trap_valid | output | 1 | Software assist request |
| trap_write | output | 1 | 1 = write to overflowed line, 0 = slot overflow |
| trap_node | output | NODE_W | Node that caused the trap |
| trap_line | output | LINE_W | Line that caused the trap |

## Verification
The assertions rely on three assumptions about the environment. Requests are offered only while `req_ready` is high. `inv_ack_valid` pulses only after an invalidate for the current write has gone out, and never more often than invalidates were sent. `fwd_rsp_valid` pulses only while a forward is outstanding. The stimulus keeps to these rules: each task waits for `req_ready` before it drives a request, sends acknowledgements only after it has counted the invalidate messages, and sends a forward reply only after the forward message has been seen.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    LN_FREE     = 2'd0,
    LN_SHARED   = 2'd1,
    LN_OWNED    = 2'd2,
    LN_MODIFIED = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    MK_NONE      = 2'd0,
    MK_INVAL     = 2'd1,
    MK_DOWNGRADE = 2'd2,
    MK_FORWARD   = 2'd3
  } msg_kind_t;

  typedef enum logic [2:0] {
    HS_CLEAR,
    HS_IDLE,
    HS_LOOK,
    HS_FWD,
    HS_INV,
    HS_ACK
  } home_st_t;
endpackage

// File: rtl/dir_entry_ram.sv
module dir_entry_ram #(
  parameter int AW = 6,
  parameter int DW = 23
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dir_slot_scan.sv
module dir_slot_scan #(
  parameter int SLOTS  = 4,
  parameter int NODE_W = 4,
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]             vld,
  input  logic [SLOTS-1:0][NODE_W-1:0] ptr,
  input  logic [NODE_W-1:0]            node,
  output logic                         hit,
  output logic                         free_any,
  output logic [SW-1:0]                free_idx,
  output logic [SLOTS-1:0]             oth_mask,
  output logic [CW-1:0]                oth_cnt
);
  logic [SLOTS-1:0] match;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign match[i]    = vld[i] && (ptr[i] == node);
    assign oth_mask[i] = vld[i] && !match[i];
  end

  assign hit      = |match;
  assign free_any = ~&vld;

  always_comb begin
    free_idx = '0;
    oth_cnt  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = SW'(i);
    end
    for (int i = 0; i < SLOTS; i++) begin
      oth_cnt = oth_cnt + CW'(oth_mask[i]);
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES = 16,
  parameter int LINES = 64,
  parameter int SLOTS = 4,
  localparam int NODE_W = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES),
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CW     = $clog2(SLOTS + 1),
  localparam int EW     = 3 + SLOTS * (NODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [NODE_W-1:0] req_node,
  input  logic [LINE_W-1:0] req_line,
  output logic              req_ready,
  input  logic              fwd_rsp_valid,
  input  logic              fwd_rsp_dirty,
  input  logic              inv_ack_valid,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_node,
  output logic [LINE_W-1:0] msg_line,
  output logic              grant_valid,
  output logic              grant_excl,
  output logic [NODE_W-1:0] grant_node,
  output logic [LINE_W-1:0] grant_line,
  output logic              trap_valid,
  output logic              trap_write,
  output logic [NODE_W-1:0] trap_node,
  output logic [LINE_W-1:0] trap_line
);
  home_st_t hs, hs_n;
  logic [LINE_W-1:0] clr_idx, cur_line;
  logic [NODE_W-1:0] cur_node;
  logic              cur_wr;
  logic [SLOTS-1:0][NODE_W-1:0] sv_ptr;
  logic [SLOTS-1:0]  inv_mask;
  logic [CW-1:0]     ack_cnt;

  // entry read back and its fields
  logic [EW-1:0] rdata, wdata;
  logic          we;
  line_st_t      r_st;
  logic          r_ovf;
  logic [SLOTS-1:0]             r_vld;
  logic [SLOTS-1:0][NODE_W-1:0] r_ptr;
  assign r_st  = line_st_t'(rdata[1:0]);
  assign r_ovf = rdata[2];
  assign r_vld = rdata[3 +: SLOTS];
  assign r_ptr = rdata[3 + SLOTS +: SLOTS * NODE_W];

  // new entry fields
  line_st_t n_st;
  logic     n_ovf;
  logic [SLOTS-1:0]             n_vld;
  logic [SLOTS-1:0][NODE_W-1:0] n_ptr;
  assign wdata = {n_ptr, n_vld, n_ovf, n_st};

  dir_entry_ram #(.AW(LINE_W), .DW(EW)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr ((hs == HS_CLEAR) ? clr_idx : cur_line),
    .wdata (wdata),
    .raddr (req_line),
    .rdata (rdata)
  );

  logic              hit, free_any;
  logic [SW-1:0]     free_idx;
  logic [SLOTS-1:0]  oth_mask;
  logic [CW-1:0]     oth_cnt;

  dir_slot_scan #(.SLOTS(SLOTS), .NODE_W(NODE_W)) u_scan (
    .vld      (r_vld),
    .ptr      (r_ptr),
    .node     (cur_node),
    .hit      (hit),
    .free_any (free_any),
    .free_idx (free_idx),
    .oth_mask (oth_mask),
    .oth_cnt  (oth_cnt)
  );

  // lowest pending invalidate target
  logic [SW-1:0] lo_idx;
  always_comb begin
    lo_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (inv_mask[i]) lo_idx = SW'(i);
    end
  end

  // decision logic
  logic       f_grant, f_gex, f_msg, f_trap, f_twr, f_load;
  msg_kind_t  f_kind;
  logic [NODE_W-1:0] f_dst;

  always_comb begin
    hs_n = hs;  we = 1'b0;
    n_st = r_st; n_ovf = r_ovf; n_vld = r_vld; n_ptr = r_ptr;
    f_grant = 1'b0; f_gex = 1'b0; f_msg = 1'b0; f_kind = MK_NONE;
    f_dst = r_ptr[0]; f_trap = 1'b0; f_twr = 1'b0; f_load = 1'b0;
    case (hs)
      HS_CLEAR: begin
        we = 1'b1; n_st = LN_FREE; n_ovf = 1'b0; n_vld = '0; n_ptr = '0;
        if (clr_idx == LINE_W'(LINES - 1)) hs_n = HS_IDLE;
      end
      HS_IDLE: if (req_valid) hs_n = HS_LOOK;
      HS_LOOK: begin
        hs_n = HS_IDLE;
        if (cur_wr) begin
          f_trap = r_ovf; f_twr = 1'b1;
          if (oth_cnt == '0) begin
            we = 1'b1; n_st = LN_MODIFIED; n_ovf = 1'b0;
            n_vld = SLOTS'(1); n_ptr = '0; n_ptr[0] = cur_node;
            f_grant = 1'b1; f_gex = 1'b1;
          end else begin
            f_load = 1'b1; hs_n = HS_INV;
          end
        end else if (r_st == LN_FREE) begin
          we = 1'b1; n_st = LN_OWNED; n_ovf = 1'b0;
          n_vld = SLOTS'(1); n_ptr = '0; n_ptr[0] = cur_node;
          f_grant = 1'b1; f_gex = 1'b1;
        end else if (hit) begin
          f_grant = 1'b1; f_gex = (r_st != LN_SHARED);
        end else if (r_st == LN_SHARED) begin
          we = 1'b1; f_grant = 1'b1;
          if (free_any) begin
            n_vld[free_idx] = 1'b1; n_ptr[free_idx] = cur_node;
          end else begin
            n_ovf = 1'b1; f_trap = 1'b1;
          end
        end else if (r_st == LN_OWNED) begin
          we = 1'b1; n_st = LN_SHARED;
          n_vld[1] = 1'b1; n_ptr[1] = cur_node;
          f_msg = 1'b1; f_kind = MK_DOWNGRADE; f_grant = 1'b1;
        end else begin
          f_msg = 1'b1; f_kind = MK_FORWARD; f_load = 1'b1; hs_n = HS_FWD;
        end
      end
      HS_FWD: if (fwd_rsp_valid) begin
        we = 1'b1; n_ovf = 1'b0; n_ptr = '0; hs_n = HS_IDLE; f_grant = 1'b1;
        if (fwd_rsp_dirty) begin
          n_st = LN_SHARED; n_vld = SLOTS'(3);
          n_ptr[0] = sv_ptr[0]; n_ptr[1] = cur_node;
        end else begin
          n_st = LN_OWNED; n_vld = SLOTS'(1); n_ptr[0] = cur_node; f_gex = 1'b1;
        end
      end
      HS_INV: begin
        f_msg = 1'b1; f_kind = MK_INVAL; f_dst = sv_ptr[lo_idx];
        if ((inv_mask & (inv_mask - SLOTS'(1))) == '0) hs_n = HS_ACK;
      end
      HS_ACK: if (ack_cnt == '0) begin
        we = 1'b1; n_st = LN_MODIFIED; n_ovf = 1'b0;
        n_vld = SLOTS'(1); n_ptr = '0; n_ptr[0] = cur_node;
        f_grant = 1'b1; f_gex = 1'b1; hs_n = HS_IDLE;
      end
      default: hs_n = HS_IDLE;
    endcase
  end

  assign req_ready = (hs == HS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs <= HS_CLEAR; clr_idx <= '0; cur_line <= '0; cur_node <= '0;
      cur_wr <= 1'b0; sv_ptr <= '0; inv_mask <= '0; ack_cnt <= '0;
      msg_valid <= 1'b0; msg_kind <= 2'd0; msg_node <= '0; msg_line <= '0;
      grant_valid <= 1'b0; grant_excl <= 1'b0; grant_node <= '0; grant_line <= '0;
      trap_valid <= 1'b0; trap_write <= 1'b0; trap_node <= '0; trap_line <= '0;
    end else begin
      hs <= hs_n;
      if (hs == HS_CLEAR) clr_idx <= clr_idx + LINE_W'(1);
      if (hs == HS_IDLE && req_valid) begin
        cur_line <= req_line; cur_node <= req_node; cur_wr <= req_write;
      end
      if (f_load) begin
        sv_ptr <= r_ptr; inv_mask <= oth_mask; ack_cnt <= oth_cnt;
      end else begin
        if (hs == HS_INV) inv_mask[lo_idx] <= 1'b0;
        if ((hs == HS_INV || hs == HS_ACK) && inv_ack_valid && ack_cnt != '0)
          ack_cnt <= ack_cnt - CW'(1);
      end
      msg_valid   <= f_msg;  msg_kind <= f_kind;
      msg_node    <= f_dst;  msg_line <= cur_line;
      grant_valid <= f_grant; grant_excl <= f_gex;
      grant_node  <= cur_node; grant_line <= cur_line;
      trap_valid  <= f_trap; trap_write <= f_twr;
      trap_node   <= cur_node; trap_line <= cur_line;
    end
  end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int LINES = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       msg_valid,
  input logic [1:0] msg_kind,
  input logic       grant_valid,
  input logic       trap_valid
);
  localparam int CNTW = $clog2(LINES + 1) + 1;
  logic [CNTW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < CNTW'(LINES)) since_rst <= since_rst + CNTW'(1);
  end

  assert_clear_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CNTW'(LINES)) |-> !req_ready);

  assert_grant_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    grant_valid |=> !grant_valid);

  assert_trap_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> !trap_valid);

  assert_grant_at_idle_R6: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> req_ready);

  assert_inval_no_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == 2'd1) |-> !grant_valid);

  assert_msg_kind_valid_R5: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_kind != 2'd0));
endmodule

bind dir_home_ctrl dir_home_chk #(.LINES(LINES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .msg_valid   (msg_valid),
  .msg_kind    (msg_kind),
  .grant_valid (grant_valid),
  .trap_valid  (trap_valid)
);

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 16;
  localparam int LINES = 64;
  localparam int SLOTS = 4;
  localparam int NW = $clog2(NODES);
  localparam int LW = $clog2(LINES);

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [NW-1:0] req_node = '0;
  logic [LW-1:0] req_line = '0;
  logic req_ready;
  logic fwd_rsp_valid = 1'b0, fwd_rsp_dirty = 1'b0, inv_ack_valid = 1'b0;
  logic msg_valid; logic [1:0] msg_kind; logic [NW-1:0] msg_node; logic [LW-1:0] msg_line;
  logic grant_valid, grant_excl; logic [NW-1:0] grant_node; logic [LW-1:0] grant_line;
  logic trap_valid, trap_write; logic [NW-1:0] trap_node; logic [LW-1:0] trap_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .LINES(LINES), .SLOTS(SLOTS)) u0 (.*);

  int checks = 0, failures = 0;
  int mcnt = 0, gcnt = 0, tcnt = 0;
  int mk [0:31]; int mn [0:31]; int ml [0:31];
  int g_ex, g_node, g_line, t_wr, t_node, t_line;

  always @(negedge clk) begin
    if (msg_valid && mcnt < 32) begin
      mk[mcnt] = int'(msg_kind); mn[mcnt] = int'(msg_node); ml[mcnt] = int'(msg_line);
      mcnt++;
    end
    if (grant_valid) begin
      gcnt++; g_ex = int'(grant_excl); g_node = int'(grant_node); g_line = int'(grant_line);
    end
    if (trap_valid) begin
      tcnt++; t_wr = int'(trap_write); t_node = int'(trap_node); t_line = int'(trap_line);
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic clr_logs();
    mcnt = 0; gcnt = 0; tcnt = 0;
  endtask

  function automatic int count_msg(input int kind, input int node);
    int n = 0;
    for (int i = 0; i < mcnt; i++) if (mk[i] == kind && mn[i] == node) n++;
    return n;
  endfunction

  task automatic issue(input bit wr, input int nd, input int ln);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_node = NW'(nd); req_line = LW'(ln);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic acks(input int n);
    for (int i = 0; i < n; i++) begin
      inv_ack_valid = 1'b1; @(negedge clk);
    end
    inv_ack_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fwd_reply(input bit dirty);
    fwd_rsp_valid = 1'b1; fwd_rsp_dirty = dirty; @(negedge clk);
    fwd_rsp_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // shared-read that must not trap, no message, shared grant
  task automatic plain_share(input int nd, input int ln, input string tag);
    clr_logs(); issue(1'b0, nd, ln);
    check(gcnt == 1 && g_ex == 0 && mcnt == 0 && tcnt == 0,
          {tag, " shared join without message or trap"}, tcnt, 0);
  endtask

  task automatic t_reset();
    int cnt = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(req_ready == 1'b0, "R1 busy right after reset", int'(req_ready), 0);
    while (!req_ready && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == LINES, "R1 clear sweep length", cnt, LINES);
  endtask

  task automatic t_first_read();
    clr_logs(); issue(1'b0, 3, 1);
    check(gcnt == 1 && g_ex == 1 && g_node == 3 && g_line == 1,
          "R2 unused line read grants exclusive", g_ex, 1);
    check(mcnt == 0, "R2 no message on unused read", mcnt, 0);
    check(gcnt == 1, "R12 exactly one grant", gcnt, 1);
    clr_logs(); issue(1'b0, 3, 1);
    check(gcnt == 1 && g_ex == 1 && mcnt == 0, "R10 owner re-read no message", mcnt, 0);
  endtask

  task automatic t_downgrade_then_write();
    clr_logs(); issue(1'b0, 5, 1);
    check(mcnt == 1 && mk[0] == 2 && mn[0] == 3 && ml[0] == 1,
          "R3 downgrade sent to owner", mn[0], 3);
    check(gcnt == 1 && g_ex == 0 && g_node == 5, "R3 shared grant", g_ex, 0);
    clr_logs(); issue(1'b1, 7, 1);
    check(mcnt == 2 && count_msg(1, 3) == 1 && count_msg(1, 5) == 1,
          "R5 invalidates only to recorded holders", mcnt, 2);
    check(gcnt == 0 && req_ready == 1'b0, "R6 grant held for acks", gcnt, 0);
    acks(1);
    check(gcnt == 0, "R6 still held after one of two acks", gcnt, 0);
    acks(1);
    check(gcnt == 1 && g_ex == 1 && g_node == 7, "R6 grant after all acks", gcnt, 1);
  endtask

  task automatic t_forward();
    clr_logs(); issue(1'b0, 9, 1);
    check(mcnt == 1 && mk[0] == 3 && mn[0] == 7, "R7 forward goes to writer", mn[0], 7);
    check(gcnt == 0, "R4 no grant before forward reply", gcnt, 0);
    fwd_reply(1'b1);
    check(gcnt == 1 && g_ex == 0 && g_node == 9, "R4 dirty reply gives shared grant", g_ex, 0);
    clr_logs(); issue(1'b1, 9, 1);
    check(mcnt == 1 && count_msg(1, 7) == 1, "R4 owner and reader both recorded", mcnt, 1);
    acks(1);
    check(gcnt == 1 && g_ex == 1, "R7 writer granted", gcnt, 1);
    clr_logs(); issue(1'b0, 2, 1);
    check(mcnt == 1 && mk[0] == 3 && mn[0] == 9, "R7 forward to new sole owner", mn[0], 9);
    fwd_reply(1'b0);
    check(gcnt == 1 && g_ex == 1 && g_node == 2, "R4 clean reply gives exclusive", g_ex, 1);
    clr_logs(); issue(1'b0, 4, 1);
    check(mcnt == 1 && mk[0] == 2 && mn[0] == 2, "R4 requester became clean owner", mk[0], 2);
  endtask

  task automatic t_overflow();
    clr_logs(); issue(1'b0, 0, 2); issue(1'b0, 1, 2);
    plain_share(2, 2, "R8"); plain_share(3, 2, "R8");
    clr_logs(); issue(1'b0, 4, 2);
    check(tcnt == 1 && t_wr == 0 && t_node == 4 && t_line == 2,
          "R8 overflow trap raised", tcnt, 1);
    check(gcnt == 1 && g_ex == 0, "R8 overflow reader still granted shared", g_ex, 0);
    clr_logs(); issue(1'b1, 6, 2);
    check(tcnt == 1 && t_wr == 1, "R9 write to overflowed line traps", t_wr, 1);
    check(mcnt == 4 && count_msg(1, 0) + count_msg(1, 1) + count_msg(1, 2) + count_msg(1, 3) == 4,
          "R5 invalidates to the four slot holders", mcnt, 4);
    acks(4);
    check(gcnt == 1 && g_ex == 1, "R6 grant after four acks", gcnt, 1);
    clr_logs(); issue(1'b0, 8, 2); fwd_reply(1'b1);
    plain_share(10, 2, "R9"); plain_share(11, 2, "R9");
    clr_logs(); issue(1'b0, 12, 2);
    check(tcnt == 1 && t_node == 12, "R9 overflow flag was cleared by write", tcnt, 1);
  endtask

  task automatic t_direct_write();
    clr_logs(); issue(1'b1, 1, 3);
    check(gcnt == 1 && g_ex == 1 && mcnt == 0, "R11 write to unused line immediate", mcnt, 0);
    clr_logs(); issue(1'b1, 1, 3);
    check(gcnt == 1 && g_ex == 1 && mcnt == 0 && tcnt == 0,
          "R11 write by sole owner immediate", mcnt, 0);
    clr_logs(); issue(1'b0, 5, 3);
    check(mcnt == 1 && mk[0] == 3 && mn[0] == 1, "R7 owner write leaves line dirty", mk[0], 3);
    fwd_reply(1'b1);
  endtask

  initial begin
    t_reset();
    t_first_read();
    t_downgrade_then_write();
    t_forward();
    t_overflow();
    t_direct_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule